// File: doc/BRIEF.md
# Paged Host Register Block with Remote DMA Port

This block is the host-facing register interface of an 8-bit network controller. A host processor reaches it through a 5-bit offset, an 8-bit data bus and single-cycle read and write strobes. A command register at offset 0x00 chooses which bank of registers the lower offsets reach. It also starts a remote read, starts a remote write or stops the current one, and it starts or stops the controller.

A remote transfer moves bytes between one data port at offset 0x10 and a 16-bit-addressed local packet RAM outside the block. The host loads a start address and a byte count, then issues the command. During a remote write, each host write to the data port stores one byte into the RAM. During a remote read, the next byte is fetched in advance, so reads of the data port return RAM bytes with no wait state, even on consecutive cycles. When the count runs out, a completion flag is raised in an interrupt status register. That register is cleared by writing ones to it and is combined with a mask register to drive one interrupt line. Any access to offset 0x1F forces the controller back into its reset state.

Top module: `nic_host_regs`

## Requirements
- R1: After `rst_n` is asserted, the status register reads 0x80, the command register reads 0x21, the mask, start address, byte count and bank-1 storage all read 0x00, and `irq` is low.
- R2: Command bits 7:6 select the page. On page 0, offsets 0x08/0x09 are the start address (low/high byte) and 0x0A/0x0B are the byte count (low/high byte). On page 1, offsets 0x01 to 0x0F are a separate 15-byte store that reads back what was written. On pages 2 and 3, writes below 0x10 (except 0x00) have no effect and reads return 0x00.
- R3: A command write with bits 5:3 = 010 (for example 0x12) and a nonzero count starts a remote write. Each later host write to 0x10 stores the data byte at the current address in the same cycle, then the address steps up by one and the count steps down by one.
- R4: When the count reaches zero, status bit 6 is set and the transfer ends. After that, data-port writes leave RAM and the address unchanged, and data-port reads return 0x00. A start command issued with a count of zero sets bit 6 at once.
- R5: A command write with bits 5:3 = 001 (for example 0x0A) starts a remote read. Every read of 0x10 returns the byte at the current address, whether reads come on consecutive cycles or spaced apart.
- R6: A page-0 write to offset 0x07 clears each of status bits 6:0 that is written as 1 and leaves bit 7 alone. A status event arriving in the same cycle as its clear leaves the bit set.
- R7: A command write with bit 1 = 1 and bit 0 = 0 (for example 0x22) clears status bit 7. A command with bit 5 = 1 stops any remote transfer without setting bit 6, and later data-port accesses have no effect.
- R8: Any read or write of offset 0x1F has the reset effects of R1 on the status register, command register, mask, address, count and transfer, but keeps the bank-1 store.
- R9: The command register reads as {page, transfer code, `tx_busy`, start, stop}. The transfer code is 100 when idle, 010 during a remote write and 001 during a remote read.
- R10: `irq` is high exactly when some bit of status bits 6:0 is set while the same bit of the mask at page-0 offset 0x0F is set. The mask reads back at that offset.
- R11: A high bit of `ext_evt[5:0]` in a cycle sets the matching status bit 5:0.
- R12: `host_rdata` is 0x00 whenever `host_rd` is low, and reads of offsets 0x11 to 0x1E return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 5 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe, one access per high cycle |
| host_rd | input | 1 | Read strobe, one access per high cycle |
| host_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Masked interrupt request |
| ext_evt | input | 6 | Status event pulses from the frame engine |
| tx_busy | input | 1 | Transmission in progress, shown in command bit 2 |
| ram_addr | output | 16 | Local RAM address |
| ram_wdata | output | 8 | Local RAM write data |
| ram_we | output | 1 | Local RAM write enable |
| ram_re | output | 1 | Local RAM read enable, data on the next cycle |
| ram_rdata | input | 8 | Local RAM read data |

## Verification
The hardest situation to reach is a data-port read that arrives in the very cycle the previous prefetch returns. In that case the byte must be forwarded straight from the RAM rather than from the holding register. The bench holds the read strobe high over several cycles so that this path is used, and it also leaves a gap after the start command so that the holding-register path is used. Two other edges are forced with explicit stimulus: a status event in the same cycle as its clear, and a stop command in the middle of a remote write.

// File: rtl/nic_host_pkg.sv
package nic_host_pkg;

    localparam int OFS_W = 5;

    localparam logic [OFS_W-1:0] OFS_CMD    = 5'h00;
    localparam logic [OFS_W-1:0] OFS_STAT   = 5'h07;
    localparam logic [OFS_W-1:0] OFS_SA_LO  = 5'h08;
    localparam logic [OFS_W-1:0] OFS_SA_HI  = 5'h09;
    localparam logic [OFS_W-1:0] OFS_CNT_LO = 5'h0A;
    localparam logic [OFS_W-1:0] OFS_CNT_HI = 5'h0B;
    localparam logic [OFS_W-1:0] OFS_MASK   = 5'h0F;
    localparam logic [OFS_W-1:0] OFS_DATA   = 5'h10;
    localparam logic [OFS_W-1:0] OFS_RESET  = 5'h1F;

    localparam logic [2:0] XFER_READ  = 3'b001;
    localparam logic [2:0] XFER_WRITE = 3'b010;
    localparam logic [2:0] XFER_IDLE  = 3'b100;

    typedef enum logic [1:0] {
        DMA_IDLE  = 2'd0,
        DMA_WRITE = 2'd1,
        DMA_FETCH = 2'd2,
        DMA_READY = 2'd3
    } dma_state_e;

    typedef struct packed {
        logic cmd_wr;
        logic stat_wr;
        logic sa_lo_wr;
        logic sa_hi_wr;
        logic cnt_lo_wr;
        logic cnt_hi_wr;
        logic mask_wr;
        logic bank_wr;
        logic data_wr;
        logic data_rd;
        logic soft_rst;
    } host_dec_t;

endpackage

// File: rtl/nic_host_decode.sv
module nic_host_decode
    import nic_host_pkg::*;
(
    input  logic [OFS_W-1:0] addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [1:0]       page,
    output host_dec_t        dec
);

    logic on_p0;
    logic on_p1;
    logic low_ofs;

    always_comb begin
        on_p0   = (page == 2'd0);
        on_p1   = (page == 2'd1);
        low_ofs = (addr[OFS_W-1] == 1'b0) && (addr != OFS_CMD);

        dec.cmd_wr    = wr && (addr == OFS_CMD);
        dec.stat_wr   = wr && on_p0 && (addr == OFS_STAT);
        dec.sa_lo_wr  = wr && on_p0 && (addr == OFS_SA_LO);
        dec.sa_hi_wr  = wr && on_p0 && (addr == OFS_SA_HI);
        dec.cnt_lo_wr = wr && on_p0 && (addr == OFS_CNT_LO);
        dec.cnt_hi_wr = wr && on_p0 && (addr == OFS_CNT_HI);
        dec.mask_wr   = wr && on_p0 && (addr == OFS_MASK);
        dec.bank_wr   = wr && on_p1 && low_ofs;
        dec.data_wr   = wr && (addr == OFS_DATA);
        dec.data_rd   = rd && (addr == OFS_DATA);
        dec.soft_rst  = (wr || rd) && (addr == OFS_RESET);
    end

endmodule

// File: rtl/nic_remote_dma.sv
module nic_remote_dma
    import nic_host_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          cmd_wr,
    input  logic [2:0]    cmd_xfer,
    input  logic          sa_lo_wr,
    input  logic          sa_hi_wr,
    input  logic          cnt_lo_wr,
    input  logic          cnt_hi_wr,
    input  logic [DW-1:0] wdata,
    input  logic          data_wr,
    input  logic          data_rd,
    output logic [DW-1:0] port_rdata,
    output logic          done,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] cur_cnt,
    output logic [2:0]    xfer_code,
    output dma_state_e    state,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          ram_we,
    output logic          ram_re,
    input  logic [DW-1:0] ram_rdata
);

    localparam int HI_W = AW - DW;

    dma_state_e    state_q, state_d;
    logic [AW-1:0] addr_q, addr_d;
    logic [AW-1:0] cnt_q, cnt_d;
    logic [DW-1:0] hold_q, hold_d;
    logic          last_byte;
    logic          cnt_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DMA_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else if (soft_rst) begin
            state_q <= DMA_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        last_byte  = (cnt_q == AW'(1));
        cnt_zero   = (cnt_q == '0);
        state_d    = state_q;
        addr_d     = addr_q;
        cnt_d      = cnt_q;
        hold_d     = hold_q;
        done       = 1'b0;
        ram_we     = 1'b0;
        ram_re     = 1'b0;
        ram_addr   = addr_q;
        port_rdata = '0;

        if (sa_lo_wr)  addr_d[DW-1:0]  = wdata;
        if (sa_hi_wr)  addr_d[AW-1:DW] = wdata[HI_W-1:0];
        if (cnt_lo_wr) cnt_d[DW-1:0]   = wdata;
        if (cnt_hi_wr) cnt_d[AW-1:DW]  = wdata[HI_W-1:0];

        unique case (state_q)
            DMA_IDLE: begin
            end
            DMA_WRITE: begin
                if (data_wr) begin
                    ram_we = 1'b1;
                    addr_d = addr_q + AW'(1);
                    cnt_d  = cnt_q - AW'(1);
                    if (last_byte) begin
                        done    = 1'b1;
                        state_d = DMA_IDLE;
                    end
                end
            end
            DMA_FETCH, DMA_READY: begin
                port_rdata = (state_q == DMA_FETCH) ? ram_rdata : hold_q;
                if (data_rd) begin
                    addr_d = addr_q + AW'(1);
                    cnt_d  = cnt_q - AW'(1);
                    if (last_byte) begin
                        done    = 1'b1;
                        state_d = DMA_IDLE;
                    end else begin
                        ram_re   = 1'b1;
                        ram_addr = addr_q + AW'(1);
                        state_d  = DMA_FETCH;
                    end
                end else if (state_q == DMA_FETCH) begin
                    hold_d  = ram_rdata;
                    state_d = DMA_READY;
                end
            end
        endcase

        if (cmd_wr) begin
            if (cmd_xfer[2]) begin
                state_d = DMA_IDLE;
            end else if (cmd_xfer == XFER_READ) begin
                if (cnt_zero) begin
                    done    = 1'b1;
                    state_d = DMA_IDLE;
                end else begin
                    ram_re   = 1'b1;
                    ram_addr = addr_q;
                    state_d  = DMA_FETCH;
                end
            end else if (cmd_xfer == XFER_WRITE) begin
                if (cnt_zero) begin
                    done    = 1'b1;
                    state_d = DMA_IDLE;
                end else begin
                    state_d = DMA_WRITE;
                end
            end
        end
    end

    always_comb begin
        unique case (state_q)
            DMA_IDLE:             xfer_code = XFER_IDLE;
            DMA_WRITE:            xfer_code = XFER_WRITE;
            DMA_FETCH, DMA_READY: xfer_code = XFER_READ;
        endcase
    end

    assign cur_addr  = addr_q;
    assign cur_cnt   = cnt_q;
    assign state     = state_q;
    assign ram_wdata = wdata;

endmodule

// File: rtl/nic_irq_status.sv
module nic_irq_status #(
    parameter int EVT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             stat_wr,
    input  logic             mask_wr,
    input  logic             run_cmd,
    input  logic [7:0]       wdata,
    input  logic             dma_done,
    input  logic [EVT_W-1:0] ext_evt,
    output logic [7:0]       stat,
    output logic [7:0]       mask,
    output logic             irq
);

    localparam int SRC_W = EVT_W + 1;

    logic             in_reset_q;
    logic [SRC_W-1:0] src_q, src_d;
    logic [7:0]       mask_q;

    always_comb begin
        src_d = src_q;
        if (stat_wr) src_d = src_d & ~wdata[SRC_W-1:0];
        src_d = src_d | {dma_done, ext_evt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_reset_q <= 1'b1;
            src_q      <= '0;
            mask_q     <= '0;
        end else if (soft_rst) begin
            in_reset_q <= 1'b1;
            src_q      <= '0;
            mask_q     <= '0;
        end else begin
            if (run_cmd) in_reset_q <= 1'b0;
            src_q <= src_d;
            if (mask_wr) mask_q <= wdata;
        end
    end

    assign stat = {in_reset_q, src_q};
    assign mask = mask_q;
    assign irq  = |(src_q & mask_q[SRC_W-1:0]);

endmodule

// File: rtl/nic_host_regs.sv
module nic_host_regs
    import nic_host_pkg::*;
#(
    parameter int RAM_AW = 16,
    parameter int EVT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        host_addr,
    input  logic [7:0]        host_wdata,
    input  logic              host_wr,
    input  logic              host_rd,
    output logic [7:0]        host_rdata,
    output logic              irq,
    input  logic [EVT_W-1:0]  ext_evt,
    input  logic              tx_busy,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    output logic              ram_re,
    input  logic [7:0]        ram_rdata
);

    localparam int BANK_N = (1 << (OFS_W - 1)) - 1;

    host_dec_t         dec;
    logic [1:0]        page_q;
    logic              sta_q;
    logic              stp_q;
    logic [7:0]        bank_q [1:BANK_N];
    logic [7:0]        port_rdata;
    logic              dma_done;
    logic [RAM_AW-1:0] dma_addr;
    logic [RAM_AW-1:0] dma_cnt;
    logic [2:0]        xfer_code;
    dma_state_e        dma_state;
    logic [7:0]        stat;
    logic [7:0]        mask;
    logic              run_cmd;

    nic_host_decode u_dec (
        .addr (host_addr),
        .wr   (host_wr),
        .rd   (host_rd),
        .page (page_q),
        .dec  (dec)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= 2'd0;
            sta_q  <= 1'b0;
            stp_q  <= 1'b1;
        end else if (dec.soft_rst) begin
            page_q <= 2'd0;
            sta_q  <= 1'b0;
            stp_q  <= 1'b1;
        end else if (dec.cmd_wr) begin
            page_q <= host_wdata[7:6];
            sta_q  <= host_wdata[1];
            stp_q  <= host_wdata[0];
        end
    end

    assign run_cmd = dec.cmd_wr && host_wdata[1] && !host_wdata[0];

    for (genvar g = 1; g <= BANK_N; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (dec.bank_wr && (host_addr == OFS_W'(g)))
                bank_q[g] <= host_wdata;
        end
    end

    nic_remote_dma #(
        .AW (RAM_AW),
        .DW (8)
    ) u_dma (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (dec.soft_rst),
        .cmd_wr     (dec.cmd_wr),
        .cmd_xfer   (host_wdata[5:3]),
        .sa_lo_wr   (dec.sa_lo_wr),
        .sa_hi_wr   (dec.sa_hi_wr),
        .cnt_lo_wr  (dec.cnt_lo_wr),
        .cnt_hi_wr  (dec.cnt_hi_wr),
        .wdata      (host_wdata),
        .data_wr    (dec.data_wr),
        .data_rd    (dec.data_rd),
        .port_rdata (port_rdata),
        .done       (dma_done),
        .cur_addr   (dma_addr),
        .cur_cnt    (dma_cnt),
        .xfer_code  (xfer_code),
        .state      (dma_state),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .ram_rdata  (ram_rdata)
    );

    nic_irq_status #(
        .EVT_W (EVT_W)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (dec.soft_rst),
        .stat_wr  (dec.stat_wr),
        .mask_wr  (dec.mask_wr),
        .run_cmd  (run_cmd),
        .wdata    (host_wdata),
        .dma_done (dma_done),
        .ext_evt  (ext_evt),
        .stat     (stat),
        .mask     (mask),
        .irq      (irq)
    );

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (host_addr == OFS_CMD) begin
                host_rdata = {page_q, xfer_code, tx_busy, sta_q, stp_q};
            end else if (host_addr == OFS_DATA) begin
                host_rdata = port_rdata;
            end else if (page_q == 2'd0) begin
                unique case (host_addr)
                    OFS_STAT:   host_rdata = stat;
                    OFS_SA_LO:  host_rdata = dma_addr[7:0];
                    OFS_SA_HI:  host_rdata = 8'(dma_addr >> 8);
                    OFS_CNT_LO: host_rdata = dma_cnt[7:0];
                    OFS_CNT_HI: host_rdata = 8'(dma_cnt >> 8);
                    OFS_MASK:   host_rdata = mask;
                    default:    host_rdata = '0;
                endcase
            end else if (page_q == 2'd1 && !host_addr[OFS_W-1]) begin
                host_rdata = bank_q[host_addr[OFS_W-2:0]];
            end
        end
    end

endmodule

// File: rtl/nic_host_regs_chk.sv
module nic_host_regs_chk
    import nic_host_pkg::*;
#(
    parameter int RAM_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic              ram_we,
    input logic              ram_re,
    input dma_state_e        dma_state,
    input logic [RAM_AW-1:0] dma_addr,
    input logic [RAM_AW-1:0] dma_cnt,
    input logic [7:0]        stat,
    input logic [7:0]        mask,
    input logic              irq
);

    a_r3_store_needs_port_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (host_wr && host_addr == OFS_DATA));

    a_r3_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (dma_addr == $past(dma_addr) + RAM_AW'(1)));

    a_r4_active_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_state != DMA_IDLE) |-> (dma_cnt != '0));

    a_r5_one_ram_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_we, ram_re}));

    a_r8_reset_port: assert property (@(posedge clk) disable iff (!rst_n)
        ((host_wr || host_rd) && host_addr == OFS_RESET) |=> (stat[7] && dma_state == DMA_IDLE && mask == 8'h00));

    a_r10_no_irq_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[6:0] == 7'd0) |-> !irq);

endmodule

bind nic_host_regs nic_host_regs_chk #(.RAM_AW(RAM_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .dma_state (dma_state),
    .dma_addr  (dma_addr),
    .dma_cnt   (dma_cnt),
    .stat      (stat),
    .mask      (mask),
    .irq       (irq)
);

// File: tb/sim_nic_host_regs.sv
`timescale 1ns/1ps
module sim_nic_host_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_rdata;
    logic        irq;
    logic [5:0]  ext_evt = '0;
    logic        tx_busy = 1'b0;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic        ram_re;
    logic [7:0]  ram_q = '0;
    logic [7:0]  mem [0:255];

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    nic_host_regs u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .irq        (irq),
        .ext_evt    (ext_evt),
        .tx_busy    (tx_busy),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .ram_we     (ram_we),
        .ram_re     (ram_re),
        .ram_rdata  (ram_q)
    );

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
        if (ram_re) ram_q <= mem[ram_addr[7:0]];
    end

    function automatic logic [7:0] fill(input int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    // {req tag, op (1 = read and compare), offset, data or expected}
    localparam int NV = 23;
    localparam logic [17:0] VEC [NV] = '{
        {4'd1,  1'b1, 5'h07, 8'h80},  // R1 status after reset
        {4'd1,  1'b1, 5'h00, 8'h21},  // R1 command after reset
        {4'd7,  1'b0, 5'h00, 8'h22},  // R7 run
        {4'd7,  1'b1, 5'h07, 8'h00},  // R7 bit 7 cleared
        {4'd9,  1'b1, 5'h00, 8'h22},  // R9 format
        {4'd2,  1'b0, 5'h08, 8'h34},
        {4'd2,  1'b0, 5'h09, 8'h12},
        {4'd2,  1'b1, 5'h08, 8'h34},  // R2 start address low
        {4'd2,  1'b1, 5'h09, 8'h12},  // R2 start address high
        {4'd2,  1'b0, 5'h00, 8'h62},  // page 1
        {4'd2,  1'b0, 5'h08, 8'hA5},
        {4'd2,  1'b0, 5'h0F, 8'h3C},
        {4'd2,  1'b1, 5'h08, 8'hA5},  // R2 bank readback
        {4'd2,  1'b1, 5'h0F, 8'h3C},
        {4'd9,  1'b1, 5'h00, 8'h62},  // R9 page field
        {4'd2,  1'b0, 5'h00, 8'h22},
        {4'd2,  1'b1, 5'h08, 8'h34},  // R2 bank write did not reach page 0
        {4'd10, 1'b1, 5'h0F, 8'h00},  // R10 mask untouched
        {4'd2,  1'b0, 5'h00, 8'hA2},  // page 2
        {4'd2,  1'b0, 5'h05, 8'h77},
        {4'd2,  1'b1, 5'h05, 8'h00},  // R2 page 2 reads zero
        {4'd12, 1'b1, 5'h15, 8'h00},  // R12 unused offset
        {4'd2,  1'b0, 5'h00, 8'h22}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mem[i] = fill(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R12 idle bus", host_rdata, 8'h00);
        chk("R1 irq low", {7'd0, irq}, 8'h00);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][13]) begin
                rd(VEC[k][12:8], v);
                chk($sformatf("R%0d vector %0d", VEC[k][17:14], k), v, VEC[k][7:0]);
            end else begin
                wr(VEC[k][12:8], VEC[k][7:0]);
            end
        end

        // R3 / R4 remote write of four bytes at 0x0030
        wr(5'h08, 8'h30); wr(5'h09, 8'h00); wr(5'h0A, 8'h04); wr(5'h0B, 8'h00);
        wr(5'h00, 8'h12);
        rdchk("R3 command while writing", 5'h00, 8'h12);
        wr(5'h10, 8'h11); wr(5'h10, 8'h22); wr(5'h10, 8'h33);
        rdchk("R4 no done before last", 5'h07, 8'h00);
        rdchk("R3 count mid", 5'h0A, 8'h01);
        wr(5'h10, 8'h44);
        rdchk("R4 done flag", 5'h07, 8'h40);
        rdchk("R4 idle code", 5'h00, 8'h22);
        wr(5'h10, 8'hEE);
        @(negedge clk);
        chk("R3 byte 0", mem[8'h30], 8'h11);
        chk("R3 byte 3", mem[8'h33], 8'h44);
        chk("R4 extra write ignored", mem[8'h34], fill(8'h34));
        rdchk("R4 address held", 5'h08, 8'h34);
        rdchk("R4 extra read zero", 5'h10, 8'h00);

        // R6 / R10 clear and mask
        wr(5'h07, 8'h80);
        rdchk("R6 bit 7 write no effect", 5'h07, 8'h40);
        wr(5'h0F, 8'h40);
        @(negedge clk); chk("R10 irq on", {7'd0, irq}, 8'h01);
        rdchk("R10 mask readback", 5'h0F, 8'h40);
        wr(5'h0F, 8'h01);
        @(negedge clk); chk("R10 irq masked", {7'd0, irq}, 8'h00);
        wr(5'h07, 8'h40);
        rdchk("R6 clear bit 6", 5'h07, 8'h00);

        // R11 events, R6 same-cycle set and clear
        @(negedge clk); ext_evt = 6'b000101;
        @(negedge clk); ext_evt = '0;
        rdchk("R11 event bits", 5'h07, 8'h05);
        @(negedge clk); chk("R10 irq from event", {7'd0, irq}, 8'h01);
        @(negedge clk);
        host_addr = 5'h07; host_wdata = 8'h05; host_wr = 1'b1; ext_evt = 6'b000001;
        @(negedge clk);
        host_wr = 1'b0; ext_evt = '0;
        rdchk("R6 set wins over clear", 5'h07, 8'h01);
        wr(5'h07, 8'hFF);
        rdchk("R6 clear all", 5'h07, 8'h00);

        // R5 remote read of five bytes from 0x0030
        wr(5'h08, 8'h30); wr(5'h0A, 8'h05);
        wr(5'h00, 8'h0A);
        rdchk("R5 command while reading", 5'h00, 8'h0A);
        @(negedge clk);
        host_addr = 5'h10; host_rd = 1'b1;
        #1 chk("R5 read 0 (held)", host_rdata, 8'h11);
        @(negedge clk); #1 chk("R5 read 1 (forwarded)", host_rdata, 8'h22);
        @(negedge clk); #1 chk("R5 read 2 (forwarded)", host_rdata, 8'h33);
        @(negedge clk); host_rd = 1'b0;
        repeat (2) @(negedge clk);
        rdchk("R5 read 3 spaced", 5'h10, 8'h44);
        rdchk("R4 no done before last read", 5'h07, 8'h00);
        rdchk("R5 read 4", 5'h10, fill(8'h34));
        rdchk("R4 read done", 5'h07, 8'h40);
        rdchk("R4 read then idle", 5'h10, 8'h00);
        wr(5'h07, 8'hFF);

        // R7 stop during a remote write
        wr(5'h08, 8'h40); wr(5'h0A, 8'h03);
        wr(5'h00, 8'h12);
        wr(5'h10, 8'h99);
        wr(5'h00, 8'h22);
        rdchk("R7 stopped code", 5'h00, 8'h22);
        rdchk("R7 no done on stop", 5'h07, 8'h00);
        wr(5'h10, 8'h88);
        @(negedge clk);
        chk("R7 written before stop", mem[8'h40], 8'h99);
        chk("R7 write after stop ignored", mem[8'h41], fill(8'h41));
        rdchk("R7 address after stop", 5'h08, 8'h41);

        // R4 zero count start
        wr(5'h0A, 8'h00);
        wr(5'h00, 8'h12);
        rdchk("R4 zero count done", 5'h07, 8'h40);
        rdchk("R4 zero count idle", 5'h00, 8'h22);

        // R9 transmit busy
        tx_busy = 1'b1;
        rdchk("R9 busy bit", 5'h00, 8'h26);
        tx_busy = 1'b0;

        // R8 reset port
        wr(5'h0F, 8'h40);
        wr(5'h08, 8'h55);
        rd(5'h1F, v);
        rdchk("R8 status", 5'h07, 8'h80);
        rdchk("R8 command", 5'h00, 8'h21);
        rdchk("R8 mask", 5'h0F, 8'h00);
        rdchk("R8 address", 5'h08, 8'h00);
        @(negedge clk); chk("R8 irq", {7'd0, irq}, 8'h00);
        wr(5'h00, 8'h61);
        rdchk("R8 bank kept", 5'h08, 8'hA5);

        // R1 hardware reset clears the bank
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rdchk("R1 status", 5'h07, 8'h80);
        wr(5'h00, 8'h61);
        rdchk("R1 bank cleared", 5'h08, 8'h00);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule